// File: doc/BRIEF.md
# Byte-Serial CRC-16 Accumulator with Register Access

This block computes a 16-bit CRC over a stream of bytes that software delivers one register write at a time. A 16-bit register port gives access to three locations: a control word, a data-input word and a result word. Each write to the data-input word folds its low byte into the running CRC and bumps an item counter. The counter can be read back through the control word. Setting the clear bit of the control word restarts both the CRC and the counter.

The CRC uses the generator x^16 + x^12 + x^5 + 1 in reflected form, so bits are shifted out least significant first (constant 0x8408). The register starts at 0xFFFF and the result is the bitwise complement of the running state. With this choice, a fixed four-byte check sequence gives a known value. Driver software runs that sequence at power-up, compares the count and the result, treats a mismatch as a dead device, and then clears the engine before normal use.

Top module: `crc16_regengine`

## Requirements
- R1: After the synchronous active-low reset, the control word (offset 0x0) reads 0x0000 and the result word (offset 0x4) reads 0x0000.
- R2: A write to the data-input word (offset 0x2) updates the CRC with bits 7:0 of the written value. The update uses polynomial 0x8408 in reflected form, least significant bit first, with a starting state of 0xFFFF. The result word reads the running state XOR 0xFFFF. Bits 15:8 of the written value have no effect on the result.
- R3: Each write to the data-input word adds one to the item count, which reads back in bits 11:0 of the control word. Bits 14:12 of the control word read as zero.
- R4: The item count saturates at 0xFFF. Further data-input writes leave it at 0xFFF, but they still update the CRC.
- R5: A control-word write with bit 15 set clears the count to 0 and restarts the CRC, so the result reads 0x0000. A control-word write with bit 15 clear changes nothing. Bit 15 of the control word always reads as 0.
- R6: After a clear, writing 0xCC, 0xF5, 0xF1 and 0xA7 gives a count of 4 and a result of 0x51DF.
- R7: The count and the result that follow a data-input write can be read in the cycle right after that write's clock edge.
- R8: Writes to the result word are ignored. Reads from any offset other than 0x0, 0x2 and 0x4 return 0x0000, and the data-input word reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe for the register port |
| bus_wr | input | 1 | 1 = write, 0 = read (valid with bus_sel) |
| bus_addr | input | 4 | Byte offset of the accessed word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address; 0 when bus_sel is low or bus_wr is high |

## Verification
A corrupted CRC state shows up in the result word at the first read after the write that caused it. Because the state feeds every later byte, the error persists until a clear. A counter that skips, double-counts or wraps shows up in bits 11:0 of the control word one cycle after the offending write. Wrap-around is seen right after the 4096th write. A clear or a byte mask that is wired wrong breaks the fixed check sequence or the table vectors that carry junk in their upper bits, and these are read back immediately.

// File: rtl/crcreg_pkg.sv
// crcreg_pkg: shared widths, constants, offsets and the register-select type
// for the byte-serial CRC accumulator. Assumes a 16-bit register port.
package crcreg_pkg;
    localparam int DATA_W = 16;
    localparam int CRC_W  = 16;
    localparam int CNT_W  = 12;
    localparam int IN_W   = 12;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [CRC_W-1:0] POLY_REFL = 16'h8408;
    localparam logic [CRC_W-1:0] SEED      = 16'hFFFF;
    localparam logic [CRC_W-1:0] XOROUT    = 16'hFFFF;

    localparam int CLR_BIT = 15;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_DIN  = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_RES  = 4'h4;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_DIN  = 2'd2,
        SEL_RES  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/crc_byte_step.sv
// crc_byte_step: combinational one-byte update of a reflected CRC.
// It runs BYTE_W shift/xor stages in a generate chain.
// Assumes CRC_W >= BYTE_W and the LSB-first bit order.
module crc_byte_step #(
    parameter int               CRC_W  = 16,
    parameter int               BYTE_W = 8,
    parameter logic [CRC_W-1:0] POLY   = 16'h8408
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] stage [0:BYTE_W];

    // Merge the byte into the low end of the state before shifting.
    assign stage[0] = crc_in ^ {{(CRC_W-BYTE_W){1'b0}}, byte_in};

    generate
        for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
            // One bit: shift right, and apply the polynomial when the bit shifted out is 1.
            assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ POLY)
                                            : (stage[i] >> 1);
        end
    endgenerate

    assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/crc_sat_counter.sv
// crc_sat_counter: item counter with synchronous clear that holds at its
// all-ones maximum. Clear takes priority over increment. Reset is synchronous and active-low.
module crc_sat_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    // Update the count: reset or clear to zero, increment below the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (inc && count != MAXV)
            count <= count + 1'b1;
    end

    // R4
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAXV && inc && !clr) |=> (count == MAXV));
    // R3
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && count != MAXV) |=> (count == $past(count) + 1'b1));
    // R5
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(count));
endmodule

// File: rtl/crc_reg_decode.sv
// crc_reg_decode: maps a byte offset onto a register select.
// Offsets that are not mapped decode to SEL_NONE.
module crc_reg_decode
    import crcreg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    // Compare the offset against the three mapped words.
    always_comb begin
        unique case (addr)
            OFS_CTRL: sel = SEL_CTRL;
            OFS_DIN:  sel = SEL_DIN;
            OFS_RES:  sel = SEL_RES;
            default:  sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/crc16_regengine.sv
// crc16_regengine: register-mapped CRC-16 accumulator that software feeds one byte per write.
// Map: 0x0 control (bit 15 clears, bits 11:0 hold the count), 0x2 data in, 0x4 result.
// Reads are combinational. Writes act on the rising edge. Reset is synchronous and active-low.
module crc16_regengine
    import crcreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [DATA_W-1:0] IN_MASK = DATA_W'((1 << IN_W) - 1);

    reg_sel_e           reg_sel;
    logic               din_wr;
    logic               clr_wr;
    logic [DATA_W-1:0]  din_masked;
    logic [CRC_W-1:0]   crc_q;
    logic [CRC_W-1:0]   crc_next;
    logic [CNT_W-1:0]   item_cnt;

    crc_reg_decode u_dec (
        .addr (bus_addr),
        .sel  (reg_sel)
    );

    // Turn bus strobes into the clear and data-input write events.
    always_comb begin
        din_wr     = bus_sel && bus_wr && (reg_sel == SEL_DIN);
        clr_wr     = bus_sel && bus_wr && (reg_sel == SEL_CTRL) && bus_wdata[CLR_BIT];
        din_masked = bus_wdata & IN_MASK;
    end

    crc_byte_step #(
        .CRC_W  (CRC_W),
        .BYTE_W (BYTE_W),
        .POLY   (POLY_REFL)
    ) u_step (
        .crc_in  (crc_q),
        .byte_in (din_masked[BYTE_W-1:0]),
        .crc_out (crc_next)
    );

    // Hold the running CRC state: seed on reset or clear, fold in a byte on a data write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_wr)
            crc_q <= SEED;
        else if (din_wr)
            crc_q <= crc_next;
    end

    crc_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_wr),
        .inc   (din_wr),
        .count (item_cnt)
    );

    // Read mux: control shows the count (bit 15 reads 0), result shows the complemented state.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (reg_sel)
                SEL_CTRL: bus_rdata = {{(DATA_W-CNT_W){1'b0}}, item_cnt};
                SEL_RES:  bus_rdata = crc_q ^ XOROUT;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R5
    clr_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (crc_q == SEED));
    // R8
    crc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!din_wr && !clr_wr) |=> $stable(crc_q));
    // R2
    byte_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (din_wr && !clr_wr) |=> (item_cnt != '0));
    // R5
    ctrl_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_CTRL) |-> (bus_rdata[DATA_W-1] == 1'b0));
endmodule

// File: tb/crc16_regengine_tb.sv
// crc16_regengine_tb_top: table-driven checks of the CRC accumulator, then directed
// tests for reset, the clear bit, ignored writes, unmapped reads and saturation.
module crc16_regengine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_DIN  = 4'h2;
    localparam logic [3:0] A_RES  = 4'h4;

    localparam int NVEC = 6;
    localparam int VEC_N [NVEC] = '{4, 1, 2, 4, 3, 4};
    localparam logic [15:0] VEC_W [NVEC][4] = '{
        '{16'h00CC, 16'h00F5, 16'h00F1, 16'h00A7},
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'h00FF, 16'h0012, 16'h0000, 16'h0000},
        '{16'hFFCC, 16'h0AF5, 16'hF0F1, 16'h5EA7},
        '{16'h0031, 16'h0032, 16'h0033, 16'h0000},
        '{16'h0055, 16'h0055, 16'h0055, 16'h0055}
    };

    crc16_regengine dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #2.5 clk = ~clk;

    // Reference model: one reflected CRC step on the low byte
    function automatic logic [15:0] model_step(input logic [15:0] s, input logic [15:0] w);
        logic [15:0] r;
        r = s ^ {8'h00, w[7:0]};
        for (int b = 0; b < 8; b++)
            r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 16'h0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
        #0.5;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // Watchdog: count an overrun as a failure and still print the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic [15:0] st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(A_CTRL, rd); check("R1 ctrl after reset", rd, 16'h0000);
        bus_read(A_RES, rd);  check("R1 result after reset", rd, 16'h0000);

        // Table walk covering R2, R3, R6 and R7 (every write is read back in the next cycle).
        for (int v = 0; v < NVEC; v++) begin
            bus_write(A_CTRL, 16'h8000);
            st = 16'hFFFF;
            for (int k = 0; k < VEC_N[v]; k++) begin
                bus_write(A_DIN, VEC_W[v][k]);
                st = model_step(st, VEC_W[v][k]);
                bus_read(A_CTRL, rd); check("R3 R7 count after write", rd, 16'(k + 1));
                bus_read(A_RES, rd);  check("R2 R7 result after write", rd, st ^ 16'hFFFF);
            end
            if (v == 0 || v == 3) begin
                bus_read(A_CTRL, rd); check("R6 self-test count", rd, 16'h0004);
                bus_read(A_RES, rd);  check("R6 R2 self-test result", rd, 16'h51DF);
            end
        end

        // R5: a control write without bit 15 changes nothing.
        bus_write(A_CTRL, 16'h7FFF);
        bus_read(A_CTRL, rd); check("R5 ctrl write bit15=0 count", rd, 16'h0004);
        bus_read(A_RES, rd);  check("R5 ctrl write bit15=0 result", rd, st ^ 16'hFFFF);

        // R8: a result write is ignored, and unmapped offsets and the data word read 0.
        bus_write(A_RES, 16'h1234);
        bus_read(A_RES, rd);  check("R8 result write ignored", rd, st ^ 16'hFFFF);
        bus_read(A_CTRL, rd); check("R8 count after result write", rd, 16'h0004);
        bus_read(4'h6, rd);   check("R8 unmapped read", rd, 16'h0000);
        bus_read(A_DIN, rd);  check("R8 data word read", rd, 16'h0000);

        // R5: a clear restarts both the count and the CRC, and bit 15 reads 0.
        bus_write(A_CTRL, 16'h8000);
        bus_read(A_CTRL, rd); check("R5 count after clear (bit15 reads 0)", rd, 16'h0000);
        bus_read(A_RES, rd);  check("R5 result after clear", rd, 16'h0000);

        // R4: the count saturates at 0xFFF while the CRC keeps updating.
        st = 16'hFFFF;
        for (int k = 0; k < 4100; k++) begin
            bus_write(A_DIN, 16'(k));
            st = model_step(st, 16'(k));
            if (k == 4094) begin
                bus_read(A_CTRL, rd); check("R4 count reaches max", rd, 16'h0FFF);
            end
        end
        bus_read(A_CTRL, rd); check("R4 count holds at max", rd, 16'h0FFF);
        bus_read(A_RES, rd);  check("R4 CRC updates while saturated", rd, st ^ 16'hFFFF);

        // R5: a clear after saturation
        bus_write(A_CTRL, 16'hFFFF);
        bus_read(A_CTRL, rd); check("R5 clear after saturation", rd, 16'h0000);

        // R1: assert reset again in the middle of a sequence.
        bus_write(A_DIN, 16'h00AB);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_read(A_CTRL, rd); check("R1 ctrl after mid reset", rd, 16'h0000);
        bus_read(A_RES, rd);  check("R1 result after mid reset", rd, 16'h0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule